// File: doc/BRIEF.md
# Lane Ultra-Low-Power State Sequencer

This block steers one clock lane and a parameterised group of data lanes of a transmit PHY into and out of the ultra-low-power state (ULPS). It runs entirely on the escape clock. Software raises a one-cycle enter or exit request. The block then drives the PHY-side request, escape and exit lines in a fixed order and watches the PHY's active-low "lane in ULPS" status lines to learn when each step has taken effect.

On entry the data lanes go down first, and the clock lane follows only once every data lane reports ULPS. On wake-up the order is reversed. The clock lane's exit line is held for a programmable wake-up time and then dropped together with its ULPS request. Once the clock lane reports awake, the data lanes repeat the same exit procedure. Two status outputs report a fully confirmed in-ULPS or awake condition. A sticky per-lane error flag marks any lane whose status failed to move within a programmable number of cycles.

Top module: `ulps_ctrl`

## Requirements
- R1: While reset is asserted, every PHY request, escape and exit output, `in_ulps` and `awake` are low, as are all error bits. After reset the block settles and raises `awake` once the clock-lane status and all data-lane statuses read high.
- R2: An enter request accepted while `awake` is high drives `dat_esc_req` and `dat_ulps_req` high for every data lane in the same cycle. `clk_ulps_req` stays low at that point.
- R3: `clk_ulps_req` rises only after every bit of `dat_ulps_n` has been sampled low.
- R4: `in_ulps` rises only after the clock-lane status `clk_ulps_n` has also been sampled low.
- R5: An exit request taken while `in_ulps` is high raises `clk_ulps_exit`, and `clk_ulps_req` stays high for as long as `clk_ulps_exit` is high.
- R6: `clk_ulps_exit` stays high for exactly `wake_time` cycles (at least one cycle). It then falls in the same cycle as `clk_ulps_req`.
- R7: `dat_ulps_exit` rises on all data lanes only after `clk_ulps_n` has been sampled high again. It stays high for exactly `wake_time` cycles and then falls together with `dat_ulps_req` and `dat_esc_req`.
- R8: After a data-lane exit, `awake` rises only once every status input has been sampled high.
- R9: Enter requests are ignored whenever `awake` is low, including during every exit step and while in ULPS.
- R10: Exit requests are ignored unless `in_ulps` is high.
- R11: `tmo_err` holds one bit per lane: bits 0 to NUM_LANES-1 belong to the data lanes and bit NUM_LANES to the clock lane. A bit sets after its lane has been waiting for a status change for more than `tmo_limit` consecutive cycles. It stays set until the next accepted enter request clears all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| esc_clk | input | 1 | Escape clock; all logic runs on it |
| esc_rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter ULPS (one-cycle pulse or level) |
| exit_req | input | 1 | Request to leave ULPS |
| wake_time | input | WAKE_W | Exit hold time in escape clocks |
| tmo_limit | input | TMO_W | Status-change timeout in escape clocks |
| clk_ulps_n | input | 1 | Clock-lane status, low = lane in ULPS |
| dat_ulps_n | input | NUM_LANES | Data-lane status, low = lane in ULPS |
| clk_ulps_req | output | 1 | Clock-lane ULPS request |
| clk_ulps_exit | output | 1 | Clock-lane ULPS exit |
| dat_esc_req | output | NUM_LANES | Per-lane escape request |
| dat_ulps_req | output | NUM_LANES | Per-lane ULPS request |
| dat_ulps_exit | output | NUM_LANES | Per-lane ULPS exit |
| in_ulps | output | 1 | All lanes confirmed in ULPS |
| awake | output | 1 | All lanes confirmed out of ULPS |
| tmo_err | output | NUM_LANES+1 | Sticky per-lane timeout flags |

## Verification
Assertions check on every cycle that the sequence follows its ordering rules. The clock request rises only after all data lanes reported ULPS, the confirmed states rise only on sampled status, exits start only from a confirmed ULPS and the clock exit never outlives its request. They also check that an error bit never appears without a waiting lane and never clears without an accepted enter. Only the bench scenarios can show the exact hold time of each exit, that requests arriving in the wrong state leave the outputs untouched, and the precise cycle in which a timeout flag sets. A scoreboard also confirms the order of output changes across full enter and wake cycles.

// File: rtl/ulps_pkg.sv
package ulps_pkg;

    typedef enum logic [3:0] {
        ST_WAKE_WAIT,
        ST_AWAKE,
        ST_DAT_ENT,
        ST_CLK_ENT,
        ST_IN_ULPS,
        ST_CLK_EXIT,
        ST_CLK_WAIT,
        ST_DAT_EXIT
    } ulps_state_e;

endpackage

// File: rtl/ulps_fsm.sv
module ulps_fsm
    import ulps_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int WAKE_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enter_req,
    input  logic                 exit_req,
    input  logic                 clk_st_n,
    input  logic [NUM_LANES-1:0] dat_st_n,
    input  logic [WAKE_W-1:0]    wake_time,
    output ulps_state_e          state_q,
    output logic                 enter_acc
);

    typedef struct packed {
        ulps_state_e       st;
        logic [WAKE_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic all_dat_low, all_dat_high, wake_done;

    always_comb begin
        all_dat_low  = ~|dat_st_n;
        all_dat_high = &dat_st_n;
        wake_done    = ({1'b0, fsm_q.cnt} + 1'b1) >= {1'b0, wake_time};
        enter_acc    = (fsm_q.st == ST_AWAKE) && enter_req;

        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_WAKE_WAIT: begin
                if (all_dat_high && clk_st_n) fsm_d.st = ST_AWAKE;
            end
            ST_AWAKE: begin
                if (enter_req) fsm_d.st = ST_DAT_ENT;
            end
            ST_DAT_ENT: begin
                if (all_dat_low) fsm_d.st = ST_CLK_ENT;
            end
            ST_CLK_ENT: begin
                if (!clk_st_n) fsm_d.st = ST_IN_ULPS;
            end
            ST_IN_ULPS: begin
                if (exit_req) begin
                    fsm_d.st  = ST_CLK_EXIT;
                    fsm_d.cnt = '0;
                end
            end
            ST_CLK_EXIT: begin
                if (wake_done) fsm_d.st = ST_CLK_WAIT;
                else           fsm_d.cnt = fsm_q.cnt + 1'b1;
            end
            ST_CLK_WAIT: begin
                if (clk_st_n) begin
                    fsm_d.st  = ST_DAT_EXIT;
                    fsm_d.cnt = '0;
                end
            end
            ST_DAT_EXIT: begin
                if (wake_done) fsm_d.st = ST_WAKE_WAIT;
                else           fsm_d.cnt = fsm_q.cnt + 1'b1;
            end
            default: fsm_d.st = ST_WAKE_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_WAKE_WAIT;
            fsm_q.cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_q = fsm_q.st;

    AST_EXIT_ONLY_FROM_ULPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_CLK_EXIT) && ($past(fsm_q.st) != ST_CLK_EXIT) |-> $past(fsm_q.st) == ST_IN_ULPS); // R10

    AST_ENTER_ONLY_FROM_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_DAT_ENT) && ($past(fsm_q.st) != ST_DAT_ENT) |-> $past(fsm_q.st) == ST_AWAKE); // R9

endmodule

// File: rtl/ulps_lane_tmo.sv
module ulps_lane_tmo #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wait_low,
    input  logic             wait_high,
    input  logic             st_n,
    input  logic [TMO_W-1:0] limit,
    output logic             err
);

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             err;
    } tmo_t;

    tmo_t tmo_d, tmo_q;
    logic waiting;

    always_comb begin
        waiting = (wait_low && st_n) || (wait_high && !st_n);
        tmo_d   = tmo_q;
        if (!waiting) begin
            tmo_d.cnt = '0;
        end else if (tmo_q.cnt != limit) begin
            tmo_d.cnt = tmo_q.cnt + 1'b1;
        end
        if (clear) begin
            tmo_d.err = 1'b0;
        end else if (waiting && (tmo_q.cnt == limit)) begin
            tmo_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q.cnt <= '0;
            tmo_q.err <= 1'b0;
        end else begin
            tmo_q <= tmo_d;
        end
    end

    assign err = tmo_q.err;

    AST_ERR_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(waiting)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(clear)); // R11

endmodule

// File: rtl/ulps_ctrl.sv
module ulps_ctrl
    import ulps_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int WAKE_W    = 16,
    parameter int TMO_W     = 16
) (
    input  logic                 esc_clk,
    input  logic                 esc_rst_n,
    input  logic                 enter_req,
    input  logic                 exit_req,
    input  logic [WAKE_W-1:0]    wake_time,
    input  logic [TMO_W-1:0]     tmo_limit,
    input  logic                 clk_ulps_n,
    input  logic [NUM_LANES-1:0] dat_ulps_n,
    output logic                 clk_ulps_req,
    output logic                 clk_ulps_exit,
    output logic [NUM_LANES-1:0] dat_esc_req,
    output logic [NUM_LANES-1:0] dat_ulps_req,
    output logic [NUM_LANES-1:0] dat_ulps_exit,
    output logic                 in_ulps,
    output logic                 awake,
    output logic [NUM_LANES:0]   tmo_err
);

    localparam int NUM_WATCH = NUM_LANES + 1;

    ulps_state_e          state_q;
    logic                 enter_acc;
    logic                 dat_hold, dat_wait_low, dat_wait_high;
    logic                 clk_wait_low, clk_wait_high;
    logic [NUM_WATCH-1:0] lane_st_n, lane_wait_low, lane_wait_high;

    ulps_fsm #(
        .NUM_LANES (NUM_LANES),
        .WAKE_W    (WAKE_W)
    ) u_fsm (
        .clk       (esc_clk),
        .rst_n     (esc_rst_n),
        .enter_req (enter_req),
        .exit_req  (exit_req),
        .clk_st_n  (clk_ulps_n),
        .dat_st_n  (dat_ulps_n),
        .wake_time (wake_time),
        .state_q   (state_q),
        .enter_acc (enter_acc)
    );

    always_comb begin
        dat_hold      = (state_q == ST_DAT_ENT)  || (state_q == ST_CLK_ENT)  ||
                        (state_q == ST_IN_ULPS)  || (state_q == ST_CLK_EXIT) ||
                        (state_q == ST_CLK_WAIT) || (state_q == ST_DAT_EXIT);
        clk_ulps_req  = (state_q == ST_CLK_ENT) || (state_q == ST_IN_ULPS) ||
                        (state_q == ST_CLK_EXIT);
        clk_ulps_exit = (state_q == ST_CLK_EXIT);
        dat_esc_req   = {NUM_LANES{dat_hold}};
        dat_ulps_req  = {NUM_LANES{dat_hold}};
        dat_ulps_exit = {NUM_LANES{state_q == ST_DAT_EXIT}};
        in_ulps       = (state_q == ST_IN_ULPS);
        awake         = (state_q == ST_AWAKE);

        dat_wait_low  = (state_q == ST_DAT_ENT);
        dat_wait_high = (state_q == ST_WAKE_WAIT);
        clk_wait_low  = (state_q == ST_CLK_ENT);
        clk_wait_high = (state_q == ST_CLK_WAIT) || (state_q == ST_WAKE_WAIT);

        lane_st_n      = {clk_ulps_n, dat_ulps_n};
        lane_wait_low  = {clk_wait_low,  {NUM_LANES{dat_wait_low}}};
        lane_wait_high = {clk_wait_high, {NUM_LANES{dat_wait_high}}};
    end

    for (genvar g = 0; g < NUM_WATCH; g++) begin : g_tmo
        ulps_lane_tmo #(
            .TMO_W (TMO_W)
        ) u_tmo (
            .clk       (esc_clk),
            .rst_n     (esc_rst_n),
            .clear     (enter_acc),
            .wait_low  (lane_wait_low[g]),
            .wait_high (lane_wait_high[g]),
            .st_n      (lane_st_n[g]),
            .limit     (tmo_limit),
            .err       (tmo_err[g])
        );
    end

    AST_CLK_AFTER_DATA: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        $rose(clk_ulps_req) |-> $past(~|dat_ulps_n)); // R3

    AST_ULPS_CONFIRMED: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        $rose(in_ulps) |-> $past(!clk_ulps_n)); // R4

    AST_CLK_EXIT_WITH_REQ: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        clk_ulps_exit |-> clk_ulps_req); // R5

    AST_CLK_RELEASE_TOGETHER: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        $fell(clk_ulps_exit) |-> $fell(clk_ulps_req)); // R6

    AST_DAT_EXIT_AFTER_CLK: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        $rose(dat_ulps_exit[0]) |-> $past(clk_ulps_n)); // R7

    AST_AWAKE_CONFIRMED: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        $rose(awake) |-> $past((&dat_ulps_n) && clk_ulps_n)); // R8

    AST_ENTER_FROM_AWAKE: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        $rose(dat_ulps_req[0]) |-> $past(awake)); // R9

    AST_EXIT_FROM_ULPS: assert property (@(posedge esc_clk) disable iff (!esc_rst_n)
        $rose(clk_ulps_exit) |-> $past(in_ulps)); // R10

endmodule

// File: tb/ulps_ctrl_bench.sv
module ulps_ctrl_bench;

    localparam int NL = 4;
    localparam int VW = 4 + 3 * NL;

    logic          esc_clk = 1'b0;
    logic          esc_rst_n;
    logic          enter_req, exit_req;
    logic [15:0]   wake_time, tmo_limit;
    logic          clk_ulps_n;
    logic [NL-1:0] dat_ulps_n;
    logic          clk_ulps_req, clk_ulps_exit, in_ulps, awake;
    logic [NL-1:0] dat_esc_req, dat_ulps_req, dat_ulps_exit;
    logic [NL:0]   tmo_err;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];
    logic [VW-1:0] prev_vec;
    logic [VW-1:0] out_vec;

    always #10 esc_clk = ~esc_clk;

    ulps_ctrl u_ulps_ctrl (
        .esc_clk       (esc_clk),
        .esc_rst_n     (esc_rst_n),
        .enter_req     (enter_req),
        .exit_req      (exit_req),
        .wake_time     (wake_time),
        .tmo_limit     (tmo_limit),
        .clk_ulps_n    (clk_ulps_n),
        .dat_ulps_n    (dat_ulps_n),
        .clk_ulps_req  (clk_ulps_req),
        .clk_ulps_exit (clk_ulps_exit),
        .dat_esc_req   (dat_esc_req),
        .dat_ulps_req  (dat_ulps_req),
        .dat_ulps_exit (dat_ulps_exit),
        .in_ulps       (in_ulps),
        .awake         (awake),
        .tmo_err       (tmo_err)
    );

    assign out_vec = {clk_ulps_req, clk_ulps_exit, dat_esc_req, dat_ulps_req,
                      dat_ulps_exit, in_ulps, awake};

    function automatic logic [VW-1:0] vec(bit cr, bit ce, bit es, bit ur, bit ex, bit iu, bit aw);
        return {cr, ce, {NL{es}}, {NL{ur}}, {NL{ex}}, iu, aw};
    endfunction

    task automatic expect_vec(logic [VW-1:0] v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Scoreboard monitor: each change of the output vector must match the next expected item
    always @(negedge esc_clk) begin
        if (mon_en && (out_vec !== prev_vec)) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected output change actual %0h expected %0h", out_vec, prev_vec);
            end else begin
                logic [VW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_vec !== e) begin
                    errors++;
                    $display("FAIL %s sequence actual %0h expected %0h", t, out_vec, e);
                end
            end
            prev_vec = out_vec;
        end
    end

    initial begin
        repeat (50000) @(posedge esc_clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        summary();
    end

    task automatic pulse_enter();
        enter_req = 1'b1;
        @(negedge esc_clk);
        enter_req = 1'b0;
    endtask

    // Full wake-up from a confirmed ULPS (all statuses low)
    task automatic do_wake();
        int n;
        expect_vec(vec(1, 1, 1, 1, 0, 0, 0), "R5");
        expect_vec(vec(0, 0, 1, 1, 0, 0, 0), "R6");
        exit_req = 1'b1;
        @(negedge esc_clk);
        exit_req = 1'b0;
        chk("R5 clock exit raised", {31'd0, clk_ulps_exit}, 32'd1);
        enter_req = 1'b1;                     // R9: must be ignored during exit
        n = 0;
        while (clk_ulps_exit && n < 100) begin
            chk("R5 request held with exit", {31'd0, clk_ulps_req}, 32'd1);
            n++;
            @(negedge esc_clk);
        end
        enter_req = 1'b0;
        chk("R6 clock exit length", n, 32'd5);
        chk("R6 clock request released", {31'd0, clk_ulps_req}, 32'd0);
        repeat (3) @(negedge esc_clk);
        chk("R7 data exit waits for clock lane", {28'd0, dat_ulps_exit}, 32'd0);
        chk("R9 enter ignored while waking", {28'd0, dat_ulps_req}, 32'hF);
        expect_vec(vec(0, 0, 1, 1, 1, 0, 0), "R7");
        expect_vec(vec(0, 0, 0, 0, 0, 0, 0), "R7");
        clk_ulps_n = 1'b1;
        @(negedge esc_clk);
        n = 0;
        while (dat_ulps_exit[0] && n < 100) begin
            n++;
            @(negedge esc_clk);
        end
        chk("R7 data exit length", n, 32'd5);
        chk("R7 escape released with exit", {28'd0, dat_esc_req}, 32'd0);
        repeat (2) @(negedge esc_clk);
        chk("R8 awake waits for data status", {31'd0, awake}, 32'd0);
        expect_vec(vec(0, 0, 0, 0, 0, 0, 1), "R8");
        dat_ulps_n = '1;
        repeat (2) @(negedge esc_clk);
        chk("R8 awake after all high", {31'd0, awake}, 32'd1);
    endtask

    initial begin
        esc_rst_n  = 1'b0;
        enter_req  = 1'b0;
        exit_req   = 1'b0;
        wake_time  = 16'd5;
        tmo_limit  = 16'd20;
        clk_ulps_n = 1'b1;
        dat_ulps_n = '1;
        repeat (3) @(negedge esc_clk);
        chk("R1 outputs low in reset", {16'd0, out_vec}, 32'd0);
        chk("R1 errors low in reset", {27'd0, tmo_err}, 32'd0);
        esc_rst_n = 1'b1;
        @(negedge esc_clk);
        chk("R1 awake after reset", {16'd0, out_vec}, {16'd0, vec(0, 0, 0, 0, 0, 0, 1)});
        prev_vec = out_vec;
        mon_en   = 1'b1;

        // R10: exit while awake has no effect
        exit_req = 1'b1;
        @(negedge esc_clk);
        exit_req = 1'b0;
        repeat (2) @(negedge esc_clk);
        chk("R10 exit ignored when awake", {16'd0, out_vec}, {16'd0, vec(0, 0, 0, 0, 0, 0, 1)});

        // Entry
        expect_vec(vec(0, 0, 1, 1, 0, 0, 0), "R2");
        pulse_enter();
        chk("R2 data escape and ulps raised", {24'd0, dat_esc_req, dat_ulps_req}, 32'hFF);
        chk("R2 clock request low", {31'd0, clk_ulps_req}, 32'd0);
        dat_ulps_n = 4'b1000;
        repeat (2) @(negedge esc_clk);
        chk("R3 clock waits for last data lane", {31'd0, clk_ulps_req}, 32'd0);
        expect_vec(vec(1, 0, 1, 1, 0, 0, 0), "R3");
        dat_ulps_n = 4'b0000;
        repeat (2) @(negedge esc_clk);
        chk("R3 clock request after data", {31'd0, clk_ulps_req}, 32'd1);
        chk("R4 not in ulps before clock status", {31'd0, in_ulps}, 32'd0);
        expect_vec(vec(1, 0, 1, 1, 0, 1, 0), "R4");
        clk_ulps_n = 1'b0;
        repeat (2) @(negedge esc_clk);
        chk("R4 in ulps confirmed", {31'd0, in_ulps}, 32'd1);

        // R9: enter while in ULPS has no effect
        pulse_enter();
        repeat (2) @(negedge esc_clk);
        chk("R9 enter ignored in ulps", {16'd0, out_vec}, {16'd0, vec(1, 0, 1, 1, 0, 1, 0)});
        chk("R11 no errors on clean run", {27'd0, tmo_err}, 32'd0);

        do_wake();

        // R11: timeouts on a stuck data lane and a stuck clock lane
        tmo_limit = 16'd3;
        expect_vec(vec(0, 0, 1, 1, 0, 0, 0), "R11");
        enter_req = 1'b1;
        @(negedge esc_clk);
        enter_req  = 1'b0;
        dat_ulps_n = 4'b0100;
        repeat (3) @(negedge esc_clk);
        chk("R11 no error at limit", {27'd0, tmo_err}, 32'd0);
        @(negedge esc_clk);
        chk("R11 data lane 2 timeout", {27'd0, tmo_err}, 32'h04);
        chk("R3 clock held while lane stuck", {31'd0, clk_ulps_req}, 32'd0);
        expect_vec(vec(1, 0, 1, 1, 0, 0, 0), "R11");
        dat_ulps_n = 4'b0000;
        repeat (8) @(negedge esc_clk);
        chk("R11 clock lane timeout and sticky", {27'd0, tmo_err}, 32'h14);
        expect_vec(vec(1, 0, 1, 1, 0, 1, 0), "R11");
        clk_ulps_n = 1'b0;
        repeat (2) @(negedge esc_clk);
        tmo_limit = 16'd20;

        do_wake();
        chk("R11 errors kept after wake", {27'd0, tmo_err}, 32'h14);

        tmo_limit = 16'd1000;
        expect_vec(vec(0, 0, 1, 1, 0, 0, 0), "R11");
        pulse_enter();
        chk("R11 errors cleared by enter", {27'd0, tmo_err}, 32'd0);
        repeat (2) @(negedge esc_clk);
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        summary();
    end

endmodule